// File: doc/BRIEF.md
# Programmed-I/O Sector Read Engine

This block is the data path that a floppy-style disk controller uses when a host reads sectors without a DMA channel. The host writes a nine-byte read command into the data register. The engine then presents the sector contents one byte per host read of that same register. When the last requested byte has been taken, it raises an interrupt and offers seven status bytes. Reading the seventh of these drops the interrupt and returns the engine to the command phase.

Sector contents come from a fixed arithmetic pattern of the sector number and the byte offset, so no media model is needed. The requested end sector is compared with the number of sectors on a track. A request that reaches beyond the last sector wraps around to sector 1, and it is reported with a different completion code. All host access is a single cycle on a small register window. Read data is combinational from the address, and the read strobe advances the byte pointer at the clock edge.

Top module: `fdpio_read_engine`

## Requirements
- R1: After reset the status register (offset 4) reads 0x80, the control register (offset 2) reads 0x08, and irq is low.
- R2: A command starts only when byte 0xE6 is written to offset 5 while bit 3 of the control register is clear. Any other first byte, or any byte while bit 3 is set, is ignored and status stays 0x80. While further command bytes are outstanding, status reads 0x90. The command is nine bytes in this order: opcode, unit select, cylinder, head, start sector, size code, end sector, gap, gap length.
- R3: From the cycle after the ninth command byte until the data phase ends, status reads 0xF0 and irq stays low. The status bits are: bit 7 ready for host, bit 6 data toward host, bit 5 programmed-I/O transfer, bit 4 busy.
- R4: Each read of offset 5 during the data phase returns ((s*37 + o[7:0]) XOR o[15:8]) mod 256, where s is the current sector and o is the byte offset in the sector. A sector holds 128<<N bytes, with N the size code clamped to 3.
- R5: Sectors are read from the start sector onward. The count is end-start+1, or 1 when the end sector is below the start sector. After sector 18 the next sector is 1.
- R6: Right after the last data byte is read, irq is high and status reads 0xD0.
- R7: The result bytes, in read order, are ST0, ST1, ST2, cylinder, head, next sector and size code. ST0 is 0x04 and ST1 is 0x00 when the end sector is 18 or less. They are 0x20 and 0x80 when the end sector exceeds 18. ST2 is 0x00. The next sector is the one after the last sector read, and it wraps from 18 to 1.
- R8: irq stays high through the first six result reads. After the seventh, irq is low and status reads 0x80.
- R9: Writes to offset 5 and reads of other offsets during the data phase do not move the byte pointer.
- R10: The control register at offset 2 stores and returns all eight bits written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset for the access |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_rdata | output | 8 | Read data for the addressed register |
| irq | output | 1 | Completion interrupt |

## Verification
The checker takes for granted that the host never raises read and write in the same cycle. It also assumes each strobe names one register for exactly one cycle. A further assumption is that the start sector of every command lies in 1..18, so the sector counter never leaves the track range. The bench drives every access through tasks that pulse a single strobe for one clock. Its random commands draw start sectors only from 1..18 and keep end sectors within a few sectors past the start, so transfers stay short and inside these limits.

// File: rtl/fdpio_pkg.sv
`timescale 1ns/1ps
package fdpio_pkg;

    localparam logic [2:0] ADDR_CTRL = 3'd2;
    localparam logic [2:0] ADDR_STAT = 3'd4;
    localparam logic [2:0] ADDR_DATA = 3'd5;

    localparam int          CTRL_DMA_BIT = 3;
    localparam logic [7:0]  CTRL_RESET   = 8'h08;
    localparam logic [7:0]  OP_PIO_READ  = 8'hE6;

    localparam int CMD_BYTES = 9;
    localparam int RES_BYTES = 7;

    localparam logic [7:0] STAT_RQM  = 8'h80;
    localparam logic [7:0] STAT_DIO  = 8'h40;
    localparam logic [7:0] STAT_NDMA = 8'h20;
    localparam logic [7:0] STAT_BUSY = 8'h10;

    localparam logic [7:0] ST0_DONE = 8'h04;
    localparam logic [7:0] ST0_OVER = 8'h20;
    localparam logic [7:0] ST1_OVER = 8'h80;

    typedef enum logic [1:0] {
        PH_CMD  = 2'd0,
        PH_DATA = 2'd1,
        PH_RES  = 2'd2
    } phase_t;

    typedef struct packed {
        logic [7:0] cyl;
        logic [7:0] head;
        logic [7:0] sector;
        logic [7:0] size;
        logic [7:0] last_sec;
    } cmd_t;

    typedef struct packed {
        logic [7:0] st0;
        logic [7:0] st1;
        logic [7:0] st2;
        logic [7:0] cyl;
        logic [7:0] head;
        logic [7:0] sec;
        logic [7:0] size;
    } res_t;

    function automatic logic [7:0] pattern_byte(input logic [7:0] sec,
                                                input logic [15:0] ofs);
        logic [7:0] mix;
        mix = sec * 8'd37 + ofs[7:0];
        return mix ^ ofs[15:8];
    endfunction

    function automatic logic [7:0] next_sector(input logic [7:0] sec,
                                               input logic [7:0] spt);
        return (sec >= spt) ? 8'd1 : sec + 8'd1;
    endfunction

endpackage

// File: rtl/fdpio_cmd.sv
`timescale 1ns/1ps
module fdpio_cmd
    import fdpio_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    input  logic       allow_start,
    output logic       busy,
    output logic       done,
    output cmd_t       cmd
);
    localparam int CNT_W = $clog2(CMD_BYTES);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(CMD_BYTES - 1);

    logic [CNT_W-1:0] cnt_q;

    assign busy = (cnt_q != '0);
    assign done = wr_en && (cnt_q == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (wr_en) begin
            if (cnt_q == '0) begin
                if (allow_start && wdata == OP_PIO_READ)
                    cnt_q <= CNT_W'(1);
            end else if (cnt_q == LAST_IDX) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd <= '0;
        end else if (wr_en) begin
            case (cnt_q)
                CNT_W'(2): cmd.cyl      <= wdata;
                CNT_W'(3): cmd.head     <= wdata;
                CNT_W'(4): cmd.sector   <= wdata;
                CNT_W'(5): cmd.size     <= wdata;
                CNT_W'(6): cmd.last_sec <= wdata;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/fdpio_xfer.sv
`timescale 1ns/1ps
module fdpio_xfer
    import fdpio_pkg::*;
#(
    parameter int SPT      = 18,
    parameter int MAX_SIZE = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] start_sec,
    input  logic [7:0] end_sec,
    input  logic [7:0] size_code,
    input  logic       advance,
    output logic [7:0] byte_o,
    output logic [7:0] cur_sec,
    output logic       last
);
    localparam int OFS_W = 7 + MAX_SIZE;
    localparam int SZ_W  = $clog2(MAX_SIZE + 1);
    localparam logic [7:0] SPT_B = 8'(SPT);
    localparam logic [7:0] MAX_B = 8'(MAX_SIZE);

    logic [OFS_W-1:0] ofs_q;
    logic [OFS_W-1:0] len_m1_q;
    logic [7:0]       sec_q;
    logic [7:0]       remain_q;

    logic [SZ_W-1:0]  szc;
    logic [OFS_W:0]   full_len;

    always_comb begin
        szc      = (size_code > MAX_B) ? SZ_W'(MAX_SIZE) : SZ_W'(size_code);
        full_len = (OFS_W+1)'(128) << szc;
    end

    assign byte_o  = pattern_byte(sec_q, 16'(ofs_q));
    assign cur_sec = sec_q;
    assign last    = (remain_q == 8'd1) && (ofs_q == len_m1_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            ofs_q    <= '0;
            len_m1_q <= '0;
            sec_q    <= 8'd1;
            remain_q <= 8'd0;
        end else if (start) begin
            ofs_q    <= '0;
            len_m1_q <= full_len[OFS_W-1:0] - OFS_W'(1);
            sec_q    <= start_sec;
            remain_q <= (end_sec >= start_sec) ? (end_sec - start_sec + 8'd1) : 8'd1;
        end else if (advance) begin
            if (ofs_q == len_m1_q) begin
                ofs_q    <= '0;
                sec_q    <= next_sector(sec_q, SPT_B);
                remain_q <= remain_q - 8'd1;
            end else begin
                ofs_q <= ofs_q + OFS_W'(1);
            end
        end
    end
endmodule

// File: rtl/fdpio_result.sv
`timescale 1ns/1ps
module fdpio_result
    import fdpio_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  res_t       rec,
    input  logic       advance,
    output logic [7:0] byte_o,
    output logic       last
);
    localparam int IDX_W = $clog2(RES_BYTES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(RES_BYTES - 1);

    logic [RES_BYTES*8-1:0] vec_q;
    logic [IDX_W-1:0]       idx_q;

    assign byte_o = vec_q[(RES_BYTES-1-int'(idx_q))*8 +: 8];
    assign last   = (idx_q == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_q <= '0;
            idx_q <= '0;
        end else if (load) begin
            vec_q <= rec;
            idx_q <= '0;
        end else if (advance) begin
            idx_q <= last ? '0 : idx_q + IDX_W'(1);
        end
    end
endmodule

// File: rtl/fdpio_read_engine.sv
`timescale 1ns/1ps
module fdpio_read_engine
    import fdpio_pkg::*;
#(
    parameter int SPT      = 18,
    parameter int MAX_SIZE = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] bus_addr,
    input  logic       bus_wr,
    input  logic [7:0] bus_wdata,
    input  logic       bus_rd,
    output logic [7:0] bus_rdata,
    output logic       irq
);
    localparam logic [7:0] SPT_B = 8'(SPT);

    logic [7:0] ctrl_q;
    phase_t     phase_q;
    logic       irq_q;

    logic       cmd_wr, cmd_done, cmd_busy;
    cmd_t       cmd;
    logic       data_rd, xfer_adv, xfer_last;
    logic [7:0] xfer_byte, xfer_sec;
    logic       res_load, res_adv, res_last;
    logic [7:0] res_byte;
    res_t       res_rec;
    logic       overrun;
    logic [7:0] status;

    assign cmd_wr   = bus_wr && (bus_addr == ADDR_DATA) && (phase_q == PH_CMD);
    assign data_rd  = bus_rd && (bus_addr == ADDR_DATA);
    assign xfer_adv = data_rd && (phase_q == PH_DATA);
    assign res_adv  = data_rd && (phase_q == PH_RES);
    assign res_load = xfer_adv && xfer_last;
    assign overrun  = (cmd.last_sec > SPT_B);

    always_comb begin
        res_rec.st0  = overrun ? ST0_OVER : ST0_DONE;
        res_rec.st1  = overrun ? ST1_OVER : 8'h00;
        res_rec.st2  = 8'h00;
        res_rec.cyl  = cmd.cyl;
        res_rec.head = cmd.head;
        res_rec.sec  = next_sector(xfer_sec, SPT_B);
        res_rec.size = cmd.size;
    end

    fdpio_cmd u_cmd (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (cmd_wr),
        .wdata       (bus_wdata),
        .allow_start (!ctrl_q[CTRL_DMA_BIT]),
        .busy        (cmd_busy),
        .done        (cmd_done),
        .cmd         (cmd)
    );

    fdpio_xfer #(.SPT(SPT), .MAX_SIZE(MAX_SIZE)) u_xfer (
        .clk       (clk),
        .rst       (rst),
        .start     (cmd_done),
        .start_sec (cmd.sector),
        .end_sec   (cmd.last_sec),
        .size_code (cmd.size),
        .advance   (xfer_adv),
        .byte_o    (xfer_byte),
        .cur_sec   (xfer_sec),
        .last      (xfer_last)
    );

    fdpio_result u_res (
        .clk     (clk),
        .rst     (rst),
        .load    (res_load),
        .rec     (res_rec),
        .advance (res_adv),
        .byte_o  (res_byte),
        .last    (res_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RESET;
        end else if (bus_wr && bus_addr == ADDR_CTRL) begin
            ctrl_q <= bus_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_CMD;
            irq_q   <= 1'b0;
        end else begin
            case (phase_q)
                PH_CMD: begin
                    if (cmd_done) phase_q <= PH_DATA;
                end
                PH_DATA: begin
                    if (res_load) begin
                        phase_q <= PH_RES;
                        irq_q   <= 1'b1;
                    end
                end
                default: begin
                    if (res_adv && res_last) begin
                        phase_q <= PH_CMD;
                        irq_q   <= 1'b0;
                    end
                end
            endcase
        end
    end

    always_comb begin
        case (phase_q)
            PH_CMD:  status = STAT_RQM | (cmd_busy ? STAT_BUSY : 8'h00);
            PH_DATA: status = STAT_RQM | STAT_DIO | STAT_NDMA | STAT_BUSY;
            default: status = STAT_RQM | STAT_DIO | STAT_BUSY;
        endcase
    end

    always_comb begin
        case (bus_addr)
            ADDR_CTRL: bus_rdata = ctrl_q;
            ADDR_STAT: bus_rdata = status;
            ADDR_DATA: begin
                case (phase_q)
                    PH_DATA: bus_rdata = xfer_byte;
                    PH_RES:  bus_rdata = res_byte;
                    default: bus_rdata = 8'h00;
                endcase
            end
            default:   bus_rdata = 8'h00;
        endcase
    end

    assign irq = irq_q;
endmodule

// File: rtl/fdpio_chk.sv
`timescale 1ns/1ps
module fdpio_chk
    import fdpio_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [2:0] bus_addr,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic [7:0] bus_rdata,
    input logic       irq,
    input phase_t     phase
);
    // Input assumption: one strobe per cycle
    p_single_strobe_r9: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd && bus_wr));

    // R6: interrupt rises only after a read of the data register
    p_irq_rise_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(bus_rd && bus_addr == ADDR_DATA));

    // R8: interrupt falls only after a read of the data register
    p_irq_fall_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(irq) |-> $past(bus_rd && bus_addr == ADDR_DATA));

    // R3: status only ever takes one of the four phase codes
    p_status_legal_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == ADDR_STAT) |->
        (bus_rdata == 8'h80 || bus_rdata == 8'h90 ||
         bus_rdata == 8'hF0 || bus_rdata == 8'hD0));

    // R6: with the interrupt pending, status shows the result phase
    p_irq_status_r6: assert property (@(posedge clk) disable iff (rst)
        (irq && bus_rd && bus_addr == ADDR_STAT) |-> (bus_rdata == 8'hD0));

    // R8: result phase always has the interrupt raised
    p_result_irq_r8: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_RES) |-> irq);
endmodule

bind fdpio_read_engine fdpio_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .phase     (phase_q)
);

// File: tb/fdpio_read_engine_test.sv
`timescale 1ns/1ps
module fdpio_read_engine_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_addr = 3'd0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic       irq;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 0;

    fdpio_read_engine uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 190000 && !done) begin
            fails = fails + 1;
            tests = tests + 1;
            $display("FAIL watchdog: actual cycles %0d expected completion", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    function automatic logic [7:0] exp_byte(input int s, input int o);
        return 8'((((s * 37) + (o % 256)) % 256) ^ (o / 256));
    endfunction

    function automatic int phys_sec(input int start, input int k);
        return ((start - 1 + k) % 18) + 1;
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        tests = tests + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        v = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic get_irq(output logic v);
        @(negedge clk); #1;
        v = irq;
    endtask

    task automatic run_read(input int start, input int eot, input int size,
                            input int cyl, input int head);
        logic [7:0] v;
        logic       iv;
        int nsect, len, last_phys, nxt, szc;
        bit over;
        bus_read(3'd4, v); check("R8 idle status before command", v, 8'h80);
        bus_write(3'd5, 8'hE6);
        bus_read(3'd4, v); check("R2 collecting status", v, 8'h90);
        bus_write(3'd5, 8'h00);
        bus_write(3'd5, 8'(cyl));
        bus_write(3'd5, 8'(head));
        bus_write(3'd5, 8'(start));
        bus_write(3'd5, 8'(size));
        bus_write(3'd5, 8'(eot));
        bus_write(3'd5, 8'h1B);
        bus_write(3'd5, 8'hFF);
        bus_read(3'd4, v); check("R3 data phase status", v, 8'hF0);
        get_irq(iv); check("R3 irq low in data phase", 8'(iv), 8'h00);
        nsect = (eot >= start) ? (eot - start + 1) : 1;
        szc = (size > 3) ? 3 : size;
        len = 128 << szc;
        for (int k = 0; k < nsect; k++) begin
            for (int o = 0; o < len; o++) begin
                if (k == 0 && o == 3) begin
                    bus_write(3'd5, 8'hE6);
                    bus_read(3'd2, v);
                    bus_read(3'd4, v); check("R9 status mid transfer", v, 8'hF0);
                end
                bus_read(3'd5, v);
                if (o == 0) check("R5 first byte of sector", v, exp_byte(phys_sec(start, k), o));
                else        check("R4 sector byte", v, exp_byte(phys_sec(start, k), o));
            end
        end
        bus_read(3'd4, v); check("R6 status after data", v, 8'hD0);
        get_irq(iv); check("R6 irq after data", 8'(iv), 8'h01);
        over = (eot > 18);
        last_phys = phys_sec(start, nsect - 1);
        nxt = (last_phys == 18) ? 1 : last_phys + 1;
        for (int r = 0; r < 7; r++) begin
            logic [7:0] e;
            get_irq(iv); check("R8 irq held during results", 8'(iv), 8'h01);
            case (r)
                0: e = over ? 8'h20 : 8'h04;
                1: e = over ? 8'h80 : 8'h00;
                2: e = 8'h00;
                3: e = 8'(cyl);
                4: e = 8'(head);
                5: e = 8'(nxt);
                default: e = 8'(size);
            endcase
            bus_read(3'd5, v); check("R7 result byte", v, e);
        end
        get_irq(iv); check("R8 irq cleared", 8'(iv), 8'h00);
        bus_read(3'd4, v); check("R8 command phase status", v, 8'h80);
    endtask

    initial begin
        logic [7:0] v;
        logic       iv;
        void'($urandom(32'd20240517));
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        bus_read(3'd4, v); check("R1 reset status", v, 8'h80);
        bus_read(3'd2, v); check("R1 reset control", v, 8'h08);
        get_irq(iv);       check("R1 reset irq", 8'(iv), 8'h00);

        bus_write(3'd2, 8'h5A);
        bus_read(3'd2, v); check("R10 control readback", v, 8'h5A);
        bus_write(3'd2, 8'hA5);
        bus_read(3'd2, v); check("R10 control readback 2", v, 8'hA5);

        bus_write(3'd2, 8'h08);
        bus_write(3'd5, 8'hE6);
        bus_read(3'd4, v); check("R2 opcode ignored with bit3 set", v, 8'h80);

        bus_write(3'd2, 8'h00);
        bus_write(3'd5, 8'h0F);
        bus_read(3'd4, v); check("R2 other opcode ignored", v, 8'h80);

        run_read(1, 1, 2, 0, 0);
        run_read(1, 18, 2, 0, 0);
        run_read(1, 19, 2, 0, 0);
        run_read(5, 3, 1, 7, 1);
        run_read(17, 20, 0, 3, 1);
        run_read(2, 2, 5, 9, 0);

        for (int i = 0; i < 6; i++) begin
            int st, en, sz;
            st = 1 + int'($urandom % 18);
            en = st + int'($urandom % 4);
            sz = int'($urandom % 4);
            run_read(st, en, sz, int'($urandom % 80), int'($urandom % 2));
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule